// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus on which a slave has been left holding SDA low, which can happen when a transfer is cut short. The controller raises `start`. The sequencer then looks at the controller's status inputs. If the bus is neither active nor holding a pending byte in its write buffer, the sequencer reports success at once. Otherwise it takes over both pins, which it drives as open-drain lines. It clocks SCL, one pulse at a time, until the slave lets go of SDA, and then hands the pins back.

Each recovery pulse has a fixed order. SCL is pulled low first, then SDA, then SCL is released, and finally SDA is released. Each phase lasts a fixed number of microseconds. A slave that stretches SCL gets two waits that grow in length before SCL is sampled. The sequence stops early once SDA reads high and SCL was seen high at the end of the previous pulse. It never issues more than the configured maximum number of pulses. After it hands the pins back and waits a settle time, the bus-active status decides the result. All times are counted in clock cycles from a cycles-per-microsecond parameter.

All ports are plain control and status pins. There is no streaming data path, so the block uses no valid/ready handshake.

Top module: `i2c_bus_clear`

## Requirements
- R1: A `start` seen while idle with `bus_active`=0 and `wr_full`=0 gives a one-cycle `done` on the next cycle, with `pass`=1 and `pulse_cnt`=0. Neither pin is driven.
- R2: No more than MAX_PULSES (default 9) recovery pulses are issued. `pulse_cnt` reports the number issued, from 0 to MAX_PULSES.
- R3: Before each pulse, the sequence ends if the synchronized SDA reads high and SCL was sampled high at the end of the previous pulse. Before the first pulse, SCL counts as not high.
- R4: Within a pulse, `scl_oe` rises first and `sda_oe` rises only while `scl_oe` is high. `scl_oe` falls while `sda_oe` is still high, and `sda_oe` falls last. Each phase lasts at least STEP_US microseconds.
- R5: If SCL is low after the post-release step, a wait of SHORT_US follows. If SCL is still low after that wait, a further wait of LONG_US follows before SCL is sampled. No long wait occurs when SCL has risen by the end of the short wait.
- R6: `scl_oe` and `sda_oe` are 0 whenever `busy` is 0. After the last pulse both pins are released, and after SETTLE_US the result `pass` is the inverse of `bus_active`.
- R7: `done` is high for exactly one cycle per sequence. A `start` that arrives while `busy` is high has no effect.
- R8: `pass` and `pulse_cnt` hold their values from one `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one recovery attempt |
| bus_active | input | 1 | Controller status: bus is busy |
| wr_full | input | 1 | Controller status: write buffer holds a byte |
| scl_in | input | 1 | Sampled SCL pin level |
| sda_in | input | 1 | Sampled SDA pin level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence strobe |
| pass | output | 1 | Result of the last sequence: 1 means the bus is free |
| pulse_cnt | output | 4 | Number of pulses issued by the last sequence |

## Verification
A wrong pulse counter or a broken early-stop test shows up at the ports as an incorrect `pulse_cnt` at `done`. For example, 9 would be reported where the modelled slave let go after 3. Such a fault surfaces one full sequence after `start`. A broken wait chain in the stretch handling changes the time from `start` to `done` by whole wait lengths. A slave held in stretch that is never given its long waits finishes far too early, and that difference is large enough to measure from the bench. Faults in pin ordering are caught within the same pulse by the checker's pin-order properties.

// File: rtl/bc_pkg.sv
package bc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SDA_LO,
    ST_SCL_REL,
    ST_SAMP_A,
    ST_SAMP_B,
    ST_SAMP_C,
    ST_FINAL,
    ST_WAIT
  } bc_state_e;

  function automatic int unsigned us_to_cyc(input int unsigned us, input int unsigned cpu);
    int unsigned v;
    v = us * cpu;
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/bc_sync.sv
module bc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '1;
          else        pipe[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '1;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/bc_timer.sv
module bc_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0) && !load;

endmodule

// File: rtl/bc_fsm.sv
module bc_fsm
  import bc_pkg::*;
#(
  parameter int MAX_PULSES = 9,
  parameter int CW         = 4,
  parameter int TW         = 16,
  parameter int STEP_CYC   = 5,
  parameter int SHORT_CYC  = 20,
  parameter int LONG_CYC   = 10000,
  parameter int SETTLE_CYC = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bus_active,
  input  logic          wr_full,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          scl_drv,
  output logic          sda_drv,
  output logic          running,
  output logic          done,
  output logic          pass,
  output logic [CW-1:0] pulses
);

  localparam logic [CW-1:0] K_MAX = CW'(MAX_PULSES);
  localparam logic [TW-1:0] T_STEP   = TW'(STEP_CYC);
  localparam logic [TW-1:0] T_SHORT  = TW'(SHORT_CYC);
  localparam logic [TW-1:0] T_LONG   = TW'(LONG_CYC);
  localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYC);

  bc_state_e st, ret_st;
  logic      scl_was_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ret_st     <= ST_IDLE;
      scl_was_hi <= 1'b0;
      scl_drv    <= 1'b0;
      sda_drv    <= 1'b0;
      done       <= 1'b0;
      pass       <= 1'b0;
      pulses     <= '0;
      tmr_load   <= 1'b0;
      tmr_val    <= '0;
    end else begin
      done     <= 1'b0;
      tmr_load <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            pulses <= '0;
            if (bus_active || wr_full) begin
              scl_was_hi <= 1'b0;
              st         <= ST_CHECK;
            end else begin
              done <= 1'b1;
              pass <= 1'b1;
            end
          end
        end
        ST_CHECK: begin
          if (pulses == K_MAX || (sda_s && scl_was_hi)) begin
            scl_drv  <= 1'b0;
            sda_drv  <= 1'b0;
            tmr_val  <= T_SETTLE;
            tmr_load <= 1'b1;
            ret_st   <= ST_FINAL;
            st       <= ST_WAIT;
          end else begin
            scl_drv  <= 1'b1;
            tmr_val  <= T_STEP;
            tmr_load <= 1'b1;
            ret_st   <= ST_SDA_LO;
            st       <= ST_WAIT;
          end
        end
        ST_SDA_LO: begin
          sda_drv  <= 1'b1;
          tmr_val  <= T_STEP;
          tmr_load <= 1'b1;
          ret_st   <= ST_SCL_REL;
          st       <= ST_WAIT;
        end
        ST_SCL_REL: begin
          scl_drv  <= 1'b0;
          tmr_val  <= T_STEP;
          tmr_load <= 1'b1;
          ret_st   <= ST_SAMP_A;
          st       <= ST_WAIT;
        end
        ST_SAMP_A: begin
          if (!scl_s) begin
            tmr_val  <= T_SHORT;
            tmr_load <= 1'b1;
            ret_st   <= ST_SAMP_B;
            st       <= ST_WAIT;
          end else begin
            st <= ST_SAMP_B;
          end
        end
        ST_SAMP_B: begin
          if (!scl_s) begin
            tmr_val  <= T_LONG;
            tmr_load <= 1'b1;
            ret_st   <= ST_SAMP_C;
            st       <= ST_WAIT;
          end else begin
            st <= ST_SAMP_C;
          end
        end
        ST_SAMP_C: begin
          scl_was_hi <= scl_s;
          sda_drv    <= 1'b0;
          pulses     <= pulses + 1'b1;
          tmr_val    <= T_STEP;
          tmr_load   <= 1'b1;
          ret_st     <= ST_CHECK;
          st         <= ST_WAIT;
        end
        ST_FINAL: begin
          done <= 1'b1;
          pass <= !bus_active;
          st   <= ST_IDLE;
        end
        ST_WAIT: begin
          if (tmr_expired) st <= ret_st;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign running = (st != ST_IDLE);

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int CYC_PER_US  = 19,
  parameter int MAX_PULSES  = 9,
  parameter int STEP_US     = 5,
  parameter int SHORT_US    = 25,
  parameter int LONG_US     = 10000,
  parameter int SETTLE_US   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bus_active,
  input  logic       wr_full,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       done,
  output logic       pass,
  output logic [3:0] pulse_cnt
);

  localparam int STEP_CYC   = int'(bc_pkg::us_to_cyc(STEP_US, CYC_PER_US));
  localparam int SHORT_CYC  = int'(bc_pkg::us_to_cyc(SHORT_US, CYC_PER_US));
  localparam int LONG_CYC   = int'(bc_pkg::us_to_cyc(LONG_US, CYC_PER_US));
  localparam int SETTLE_CYC = int'(bc_pkg::us_to_cyc(SETTLE_US, CYC_PER_US));
  localparam int MAX_CYC    = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int TW         = $clog2(MAX_CYC + 1) + 1;
  localparam int CW         = $clog2(MAX_PULSES + 1);

  logic [1:0]    pins_s;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic [CW-1:0] pulses;

  bc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     (pins_s)
  );

  bc_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  bc_fsm #(
    .MAX_PULSES (MAX_PULSES),
    .CW         (CW),
    .TW         (TW),
    .STEP_CYC   (STEP_CYC),
    .SHORT_CYC  (SHORT_CYC),
    .LONG_CYC   (LONG_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .bus_active  (bus_active),
    .wr_full     (wr_full),
    .scl_s       (pins_s[1]),
    .sda_s       (pins_s[0]),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .scl_drv     (scl_oe),
    .sda_drv     (sda_oe),
    .running     (busy),
    .done        (done),
    .pass        (pass),
    .pulses      (pulses)
  );

  assign pulse_cnt = 4'(pulses);

endmodule

// File: rtl/i2c_bus_clear_chk.sv
module i2c_bus_clear_chk #(
  parameter int MAX_PULSES = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       bus_active,
  input logic       wr_full,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic       done,
  input logic       pass,
  input logic [3:0] pulse_cnt
);

  a_r2_cnt_max: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= 4'(MAX_PULSES));

  a_r6_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe || sda_oe) |-> busy);

  a_r4_sda_under_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> scl_oe);

  a_r4_scl_released_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> sda_oe);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_quick_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !bus_active && !wr_full) |=> (done && pass && pulse_cnt == 4'd0));

endmodule

bind i2c_bus_clear i2c_bus_clear_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .bus_active (bus_active),
  .wr_full    (wr_full),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .pulse_cnt  (pulse_cnt)
);

// File: tb/tb_i2c_bus_clear.sv
module tb_i2c_bus_clear;

  localparam int CLK_PERIOD = 10;
  localparam int CPU    = 2;
  localparam int STEPU  = 5;
  localparam int SHORTU = 20;
  localparam int LONGU  = 200;
  localparam int SETU   = 10;
  localparam int LONG_C = LONGU * CPU;
  localparam int SHORT_C = SHORTU * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wr_full = 1'b0;
  logic force_active = 1'b0;
  logic scl_stuck = 1'b0;
  logic hold_en = 1'b0;
  int   release_after = 0;
  int   edges = 0;
  int   stretch_len = 0;
  int   stretch_cnt = 0;

  logic scl_oe, sda_oe, busy, done, pass;
  logic [3:0] pulse_cnt;
  logic scl_line, sda_line, holding, bus_active, scl_prev, oe_prev;

  int tests = 0;
  int fails = 0;
  int done_seen = 0;
  bit watchdog_hit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign holding    = hold_en && (edges < release_after);
  assign bus_active = force_active || holding;
  assign scl_line   = !scl_oe && !scl_stuck && (stretch_cnt == 0);
  assign sda_line   = !sda_oe && !holding;

  i2c_bus_clear #(
    .CYC_PER_US (CPU),
    .STEP_US    (STEPU),
    .SHORT_US   (SHORTU),
    .LONG_US    (LONGU),
    .SETTLE_US  (SETU)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .bus_active (bus_active),
    .wr_full    (wr_full),
    .scl_in     (scl_line),
    .sda_in     (sda_line),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .pulse_cnt  (pulse_cnt)
  );

  // bus model: slave edge counter and clock stretching
  always @(posedge clk) begin
    scl_prev <= scl_line;
    oe_prev  <= scl_oe;
    if (scl_line && !scl_prev && hold_en) edges <= edges + 1;
    if (oe_prev && !scl_oe) stretch_cnt <= stretch_len;
    else if (stretch_cnt != 0) stretch_cnt <= stretch_cnt - 1;
    if (done) done_seen <= done_seen + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input bit hen, input int rel, input bit fa, input bit wf,
                       input bit stuck, input int slen);
    @(negedge clk);
    hold_en = hen; release_after = rel; force_active = fa; wr_full = wf;
    scl_stuck = stuck; stretch_len = slen; edges = 0;
    @(negedge clk);
  endtask

  // pulses start, returns cycles until done; also injects a stray start at mid_at
  task automatic run_seq(output int cyc, input int mid_at);
    cyc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 20000) begin
      if (cyc == mid_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (cyc >= 20000) begin
      watchdog_hit = 1;
      check("watchdog", 1, 0);
    end
  endtask

  task automatic t_reset();
    check("R6 reset scl_oe", scl_oe, 0);
    check("R6 reset sda_oe", sda_oe, 0);
    check("R7 reset done", done, 0);
    check("R6 reset busy", busy, 0);
  endtask

  task automatic t_idle_bus();
    int c; int d0;
    setup(0, 0, 0, 0, 0, 0);
    d0 = done_seen;
    run_seq(c, -1);
    check("R1 immediate done", c, 0);
    check("R1 pass", pass, 1);
    check("R1 pulse_cnt", pulse_cnt, 0);
    check("R1 no pins", scl_oe | sda_oe, 0);
    @(negedge clk);
    check("R7 one done", done_seen - d0, 1);
  endtask

  task automatic t_release_three();
    int c; int d0;
    setup(1, 3, 0, 0, 0, 0);
    d0 = done_seen;
    run_seq(c, 100);
    check("R3 early stop count", pulse_cnt, 3);
    check("R6 pass after release", pass, 1);
    @(negedge clk);
    check("R7 stray start ignored", done_seen - d0, 1);
    check("R6 pins released", scl_oe | sda_oe, 0);
    repeat (20) @(negedge clk);
    check("R8 count held", pulse_cnt, 3);
    check("R8 pass held", pass, 1);
  endtask

  task automatic t_never_release();
    int c;
    setup(1, 100, 0, 0, 0, 0);
    run_seq(c, -1);
    check("R2 max pulses", pulse_cnt, 9);
    check("R6 fail when active", pass, 0);
  endtask

  task automatic t_wrfull_only();
    int c;
    setup(0, 0, 0, 1, 0, 0);
    run_seq(c, -1);
    check("R3 first pulse always", pulse_cnt, 1);
    check("R6 pass idle bus", pass, 1);
    check("R4 min duration", (c >= 4 * STEPU * CPU + SETU * CPU) ? 1 : 0, 1);
  endtask

  task automatic t_short_stretch();
    int c;
    setup(1, 1, 0, 0, 0, SHORT_C);
    run_seq(c, -1);
    check("R5 short stretch count", pulse_cnt, 1);
    check("R5 short stretch pass", pass, 1);
    check("R5 no long wait", (c < LONG_C) ? 1 : 0, 1);
    check("R5 short wait taken", (c >= SHORT_C) ? 1 : 0, 1);
  endtask

  task automatic t_stuck_scl();
    int c;
    setup(0, 0, 1, 0, 1, 0);
    run_seq(c, -1);
    check("R5 stuck count", pulse_cnt, 9);
    check("R5 stuck fail", pass, 0);
    check("R5 long waits taken", (c >= 9 * (SHORT_C + LONG_C)) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_idle_bus();
    t_release_three();
    t_never_release();
    t_wrfull_only();
    t_short_stretch();
    t_stuck_scl();
    setup(0, 0, 0, 0, 0, 0);
    t_idle_bus();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule